// File: doc/BRIEF.md
# Expanded Slot Address Decoder

This block turns a CPU memory address into one-hot device selects for a 64 kB space cut into four 16 kB pages. Each page picks one of four primary slots. Primary slot 3 is split into four sub-slots, and a second register picks one of them per page. The block holds both registers and answers CPU reads of them. The I/O and memory buses are separate, so an I/O strobe and a memory strobe may be active in the same cycle.

The device map is fixed. Slot 0 carries the main ROM. Slots 1 and 2 are cartridge connectors. Sub-slot 3-0 is the 128 kB paged RAM mapper. Sub-slot 3-1 carries the sub-ROM and the character ROM. A memory read that lands where no device sits is answered by the block with FFh, so a RAM probe never sees a floating bus. Addresses at or above 10000h bypass the page logic and go to a linear RAM select.

Top module: `slot_decoder_top`

## Requirements
- R1: After synchronous reset both slot registers are zero, so every page selects primary slot 0 and sub-slot 0. An I/O read of the primary register then returns 00h, and a memory read in page 0 selects the main ROM.
- R2: The primary register sits at I/O port A8h. Page p uses bits 2p+1:2p, so page 0 uses bits 1:0. An I/O read of A8h drives `io_rd_drive` and returns the stored value. An I/O write or read to any other port leaves the register unchanged and is not answered.
- R3: The page is address bits 15:14. In primary slot 0, pages 0 and 1 select the main ROM (`dev_cs` bit 0) and pages 2 and 3 select nothing.
- R4: In primary slot 1 every page selects cartridge A (`dev_cs` bit 1). In primary slot 2 every page selects cartridge B (`dev_cs` bit 2).
- R5: In primary slot 3 the sub-slot for page p is taken from secondary register bits 2p+1:2p. Sub-slot 0 selects the mapper (`dev_cs` bit 3) in all pages. Sub-slot 1 selects the sub-ROM (`dev_cs` bit 4) in page 0 and the character ROM (`dev_cs` bit 5) in pages 1 and 2, and nothing in page 3. Sub-slots 2 and 3 select nothing.
- R6: A memory read that selects no device, is not a linear access and is not a secondary-register access drives `mem_rd_drive` with `mem_rdata` = FFh.
- R7: The secondary register is reached through memory address FFFFh only while page 3 selects primary slot 3. A write stores `wdata`, and a read returns the bitwise inverse of the stored value. During such an access no `dev_cs` bit is set. While page 3 selects another slot, FFFFh is decoded like any other address.
- R8: A register write is transparent: in the cycle the write strobe is active, decoding already uses the value on `wdata`. From the next clock edge that value is held.
- R9: When any address bit above bit 15 is set, `linear_cs` is asserted, no `dev_cs` bit is set and the block does not drive read data.
- R10: At most one of `dev_cs` and `linear_cs` is set in any cycle.
- R11: With neither `mem_rd` nor `mem_wr` active, no select is asserted and `mem_rd_drive` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 23 | CPU memory address |
| mem_rd | input | 1 | Memory read strobe |
| mem_wr | input | 1 | Memory write strobe |
| io_addr | input | 8 | I/O port address |
| io_rd | input | 1 | I/O read strobe |
| io_wr | input | 1 | I/O write strobe |
| wdata | input | 8 | Write data |
| dev_cs | output | 6 | One-hot device select (main ROM, cart A, cart B, mapper, sub-ROM, char ROM) |
| linear_cs | output | 1 | Linear RAM select for addresses at or above 10000h |
| mem_rd_drive | output | 1 | The block drives the memory read data |
| mem_rdata | output | 8 | Memory read data from the block |
| io_rd_drive | output | 1 | The block drives the I/O read data |
| io_rdata | output | 8 | I/O read data from the block |

## Verification
Random primary and secondary values are combined with addresses spread over all four pages. This exercises every primary and sub-slot pairing, and a page-field swap would show as a wrong select. A share of the addresses have upper bits set, which separates the linear bypass from the paged decode. Directed accesses to FFFFh, once with page 3 in slot 3 and once with it in another slot, show whether the register intercept is conditional. An I/O write issued alongside a memory read shows whether the decode uses the written value in the same cycle or one cycle later.

// File: rtl/slot_pkg.sv
package slot_pkg;

    localparam int PAGES   = 4;
    localparam int SLOT_W  = 2;
    localparam int REG_W   = PAGES * SLOT_W;
    localparam int NUM_DEV = 6;

    typedef enum logic [2:0] {
        DEV_NONE     = 3'd0,
        DEV_MAIN_ROM = 3'd1,
        DEV_CART_A   = 3'd2,
        DEV_CART_B   = 3'd3,
        DEV_MAPPER   = 3'd4,
        DEV_SUB_ROM  = 3'd5,
        DEV_CHAR_ROM = 3'd6
    } dev_e;

    typedef struct packed {
        logic [SLOT_W-1:0] page;
        logic [SLOT_W-1:0] prim;
        logic [SLOT_W-1:0] sub;
    } route_t;

    // fixed device map over (page, primary slot, sub-slot)
    function automatic dev_e map_device(route_t r);
        dev_e d;
        d = DEV_NONE;
        case (r.prim)
            2'd0: if (r.page < 2'd2) d = DEV_MAIN_ROM;
            2'd1: d = DEV_CART_A;
            2'd2: d = DEV_CART_B;
            default: begin
                case (r.sub)
                    2'd0: d = DEV_MAPPER;
                    2'd1: begin
                        if (r.page == 2'd0)
                            d = DEV_SUB_ROM;
                        else if (r.page != 2'd3)
                            d = DEV_CHAR_ROM;
                    end
                    default: d = DEV_NONE;
                endcase
            end
        endcase
        return d;
    endfunction

    function automatic logic [NUM_DEV-1:0] dev_onehot(dev_e d);
        logic [NUM_DEV-1:0] v;
        v = '0;
        for (int i = 0; i < NUM_DEV; i++) begin
            if (int'(d) == i + 1) v[i] = 1'b1;
        end
        return v;
    endfunction

    function automatic logic [SLOT_W-1:0] field_of(logic [REG_W-1:0] r,
                                                   logic [SLOT_W-1:0] page);
        return r[page*SLOT_W +: SLOT_W];
    endfunction

endpackage

// File: rtl/slot_regs.sv
module slot_regs
    import slot_pkg::*;
#(
    parameter logic [7:0] PRIM_PORT = 8'hA8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             io_wr,
    input  logic [7:0]       io_addr,
    input  logic             sec_wr,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] prim_q,
    output logic [REG_W-1:0] sec_q,
    output logic [REG_W-1:0] prim_eff,
    output logic [REG_W-1:0] sec_eff
);

    logic prim_wr;

    assign prim_wr = io_wr && (io_addr == PRIM_PORT);

    always_ff @(posedge clk) begin
        if (rst) begin
            prim_q <= '0;
        end else if (prim_wr) begin
            prim_q <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sec_q <= '0;
        end else if (sec_wr) begin
            sec_q <= wdata;
        end
    end

    // write-through so a write is visible in its own cycle
    always_comb begin
        prim_eff = prim_wr ? wdata : prim_q;
        sec_eff  = sec_wr  ? wdata : sec_q;
    end

endmodule

// File: rtl/slot_page_decode.sv
module slot_page_decode
    import slot_pkg::*;
(
    input  logic [15:0]      addr16,
    input  logic [REG_W-1:0] prim_eff,
    input  logic [REG_W-1:0] sec_eff,
    output dev_e             dev,
    output logic [SLOT_W-1:0] page
);

    dev_e page_dev [PAGES];

    assign page = addr16[15:14];

    for (genvar p = 0; p < PAGES; p++) begin : g_page
        route_t r;
        always_comb begin
            r.page = SLOT_W'(p);
            r.prim = prim_eff[p*SLOT_W +: SLOT_W];
            r.sub  = sec_eff[p*SLOT_W +: SLOT_W];
            page_dev[p] = map_device(r);
        end
    end

    assign dev = page_dev[page];

endmodule

// File: rtl/slot_read_mux.sv
module slot_read_mux
    import slot_pkg::*;
#(
    parameter logic [7:0] EMPTY_VAL = 8'hFF
) (
    input  logic             io_rd,
    input  logic             io_hit,
    input  logic [REG_W-1:0] prim_q,
    input  logic             mem_rd,
    input  logic             sec_hit,
    input  logic             empty_hit,
    input  logic [REG_W-1:0] sec_q,
    output logic             io_rd_drive,
    output logic [7:0]       io_rdata,
    output logic             mem_rd_drive,
    output logic [7:0]       mem_rdata
);

    always_comb begin
        io_rd_drive = io_rd && io_hit;
        io_rdata    = io_rd_drive ? prim_q : 8'h00;
    end

    always_comb begin
        mem_rd_drive = 1'b0;
        mem_rdata    = 8'h00;
        if (mem_rd) begin
            if (sec_hit) begin
                mem_rd_drive = 1'b1;
                mem_rdata    = ~sec_q;
            end else if (empty_hit) begin
                mem_rd_drive = 1'b1;
                mem_rdata    = EMPTY_VAL;
            end
        end
    end

endmodule

// File: rtl/slot_decoder_top.sv
module slot_decoder_top
    import slot_pkg::*;
#(
    parameter int         ADDR_W    = 23,
    parameter logic [7:0] PRIM_PORT = 8'hA8,
    parameter logic [15:0] SEC_ADDR = 16'hFFFF,
    parameter logic [7:0] EMPTY_VAL = 8'hFF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              mem_rd,
    input  logic              mem_wr,
    input  logic [7:0]        io_addr,
    input  logic              io_rd,
    input  logic              io_wr,
    input  logic [7:0]        wdata,
    output logic [NUM_DEV-1:0] dev_cs,
    output logic              linear_cs,
    output logic              mem_rd_drive,
    output logic [7:0]        mem_rdata,
    output logic              io_rd_drive,
    output logic [7:0]        io_rdata
);

    localparam int HI_W = ADDR_W - 16;

    logic [REG_W-1:0]  prim_q, sec_q, prim_eff, sec_eff;
    logic              mem_act, in_linear, sec_hit, sec_wr, empty_hit, io_hit;
    dev_e              dev;
    logic [SLOT_W-1:0] page;

    assign mem_act   = mem_rd || mem_wr;
    assign in_linear = |addr[ADDR_W-1:16];
    assign io_hit    = (io_addr == PRIM_PORT);

    // secondary register intercept: page 3 must sit in primary slot 3
    assign sec_hit = mem_act && !in_linear && (addr[15:0] == SEC_ADDR)
                     && (field_of(prim_eff, 2'd3) == 2'd3);
    assign sec_wr  = sec_hit && mem_wr;

    slot_regs #(.PRIM_PORT(PRIM_PORT)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .io_wr    (io_wr),
        .io_addr  (io_addr),
        .sec_wr   (sec_wr),
        .wdata    (wdata),
        .prim_q   (prim_q),
        .sec_q    (sec_q),
        .prim_eff (prim_eff),
        .sec_eff  (sec_eff)
    );

    slot_page_decode u_decode (
        .addr16   (addr[15:0]),
        .prim_eff (prim_eff),
        .sec_eff  (sec_eff),
        .dev      (dev),
        .page     (page)
    );

    always_comb begin
        dev_cs    = '0;
        linear_cs = 1'b0;
        if (mem_act) begin
            if (in_linear)
                linear_cs = 1'b1;
            else if (!sec_hit)
                dev_cs = dev_onehot(dev);
        end
    end

    assign empty_hit = !in_linear && !sec_hit && (dev == DEV_NONE);

    slot_read_mux #(.EMPTY_VAL(EMPTY_VAL)) u_rdmux (
        .io_rd        (io_rd),
        .io_hit       (io_hit),
        .prim_q       (prim_q),
        .mem_rd       (mem_rd),
        .sec_hit      (sec_hit),
        .empty_hit    (empty_hit),
        .sec_q        (sec_q),
        .io_rd_drive  (io_rd_drive),
        .io_rdata     (io_rdata),
        .mem_rd_drive (mem_rd_drive),
        .mem_rdata    (mem_rdata)
    );

    logic [HI_W-1:0] unused_hi;
    assign unused_hi = addr[ADDR_W-1:16];

endmodule

// File: rtl/slot_decoder_chk.sv
module slot_decoder_chk
    import slot_pkg::*;
#(
    parameter logic [7:0] PRIM_PORT = 8'hA8
) (
    input logic               clk,
    input logic               rst,
    input logic               mem_rd,
    input logic               mem_wr,
    input logic [7:0]         io_addr,
    input logic               io_wr,
    input logic [7:0]         wdata,
    input logic [NUM_DEV-1:0] dev_cs,
    input logic               linear_cs,
    input logic               mem_rd_drive,
    input logic [7:0]         mem_rdata,
    input logic [REG_W-1:0]   prim_q,
    input logic [REG_W-1:0]   sec_q,
    input logic               sec_hit
);

    assert_reset_clears_R1: assert property (@(posedge clk)
        rst |=> (prim_q == '0 && sec_q == '0));

    assert_prim_capture_R2: assert property (@(posedge clk) disable iff (rst)
        (io_wr && io_addr == PRIM_PORT) |=> (prim_q == $past(wdata)));

    assert_prim_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !(io_wr && io_addr == PRIM_PORT) |=> $stable(prim_q));

    assert_empty_ff_R6: assert property (@(posedge clk) disable iff (rst)
        (mem_rd && dev_cs == '0 && !linear_cs && !sec_hit)
            |-> (mem_rd_drive && mem_rdata == 8'hFF));

    assert_sec_no_cs_R7: assert property (@(posedge clk) disable iff (rst)
        sec_hit |-> (dev_cs == '0));

    assert_linear_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        linear_cs |-> !mem_rd_drive);

    assert_one_select_R10: assert property (@(posedge clk) disable iff (rst)
        $onehot0({dev_cs, linear_cs}));

    assert_idle_R11: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd || mem_wr) |-> (dev_cs == '0 && !linear_cs && !mem_rd_drive));

endmodule

bind slot_decoder_top slot_decoder_chk #(.PRIM_PORT(PRIM_PORT)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .mem_rd       (mem_rd),
    .mem_wr       (mem_wr),
    .io_addr      (io_addr),
    .io_wr        (io_wr),
    .wdata        (wdata),
    .dev_cs       (dev_cs),
    .linear_cs    (linear_cs),
    .mem_rd_drive (mem_rd_drive),
    .mem_rdata    (mem_rdata),
    .prim_q       (prim_q),
    .sec_q        (sec_q),
    .sec_hit      (sec_hit)
);

// File: tb/test_slot_decoder_top.sv
`timescale 1ns/1ps
module test_slot_decoder_top;

    logic        clk = 1'b0;
    logic        rst;
    logic [22:0] addr;
    logic        mem_rd, mem_wr, io_rd, io_wr;
    logic [7:0]  io_addr, wdata;
    logic [5:0]  dev_cs;
    logic        linear_cs, mem_rd_drive, io_rd_drive;
    logic [7:0]  mem_rdata, io_rdata;

    int checks = 0;
    int errors = 0;
    logic [7:0] m_prim = 8'h00;
    logic [7:0] m_sec  = 8'h00;
    bit done = 1'b0;

    always #4 clk = ~clk;

    slot_decoder_top i_slot_decoder_top (
        .clk(clk), .rst(rst), .addr(addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr), .wdata(wdata),
        .dev_cs(dev_cs), .linear_cs(linear_cs), .mem_rd_drive(mem_rd_drive),
        .mem_rdata(mem_rdata), .io_rd_drive(io_rd_drive), .io_rdata(io_rdata)
    );

    function automatic bit is_sec(logic [7:0] p, logic [22:0] a);
        return (a[22:16] == 0) && (a[15:0] == 16'hFFFF) && (p[7:6] == 2'd3);
    endfunction

    function automatic logic [5:0] exp_cs(logic [7:0] p, logic [7:0] s, logic [22:0] a);
        logic [1:0] pg, sl, sb;
        if (a[22:16] != 0 || is_sec(p, a)) return 6'd0;
        pg = a[15:14];
        sl = p[2*pg +: 2];
        sb = s[2*pg +: 2];
        case (sl)
            2'd0: return (pg < 2) ? 6'b000001 : 6'd0;
            2'd1: return 6'b000010;
            2'd2: return 6'b000100;
            default: begin
                if (sb == 2'd0) return 6'b001000;
                if (sb == 2'd1) begin
                    if (pg == 2'd0) return 6'b010000;
                    if (pg != 2'd3) return 6'b100000;
                end
                return 6'd0;
            end
        endcase
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        mem_rd = 0; mem_wr = 0; io_rd = 0; io_wr = 0;
        io_addr = 8'h00; wdata = 8'h00; addr = '0;
    endtask

    // memory access, optionally with a simultaneous I/O write
    task automatic mem_access(bit rd, bit wr, logic [22:0] a, logic [7:0] d,
                              bit iow, logic [7:0] ioa, string req);
        logic [7:0] p_now;
        logic [5:0] e;
        bit sec, lin;
        @(negedge clk);
        idle_inputs();
        mem_rd = rd; mem_wr = wr; addr = a; wdata = d;
        io_wr = iow; io_addr = ioa;
        #2;
        p_now = (iow && ioa == 8'hA8) ? d : m_prim;
        sec = is_sec(p_now, a);
        lin = (a[22:16] != 0);
        e = (rd || wr) ? exp_cs(p_now, m_sec, a) : 6'd0;
        check(dev_cs == e, req, "dev_cs", dev_cs, e);
        check(linear_cs == ((rd || wr) && lin), req, "linear_cs", linear_cs, (rd || wr) && lin);
        if (rd && sec) begin
            check(mem_rd_drive && mem_rdata == ~m_sec, req, "sec readback", mem_rdata, ~m_sec);
        end else if (rd && !lin && e == 0) begin
            check(mem_rd_drive && mem_rdata == 8'hFF, req, "empty read", mem_rdata, 8'hFF);
        end else begin
            check(!mem_rd_drive, req, "no drive", mem_rd_drive, 0);
        end
        if (wr && sec && !iow) m_sec = d;
        if (iow && ioa == 8'hA8) m_prim = d;
    endtask

    task automatic io_write(logic [7:0] port, logic [7:0] d);
        @(negedge clk);
        idle_inputs();
        io_wr = 1; io_addr = port; wdata = d;
        if (port == 8'hA8) m_prim = d;
    endtask

    task automatic io_read(logic [7:0] port, string req);
        @(negedge clk);
        idle_inputs();
        io_rd = 1; io_addr = port;
        #2;
        if (port == 8'hA8)
            check(io_rd_drive && io_rdata == m_prim, req, "io readback", io_rdata, m_prim);
        else
            check(!io_rd_drive, req, "foreign port drive", io_rd_drive, 0);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        idle_inputs();
        rst = 1;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;

        // R1 reset state
        io_read(8'hA8, "R1");
        mem_access(1, 0, 23'h0010, 0, 0, 0, "R1");
        // R11 idle
        mem_access(0, 0, 23'h4000, 0, 0, 0, "R11");
        // R3 slot 0 upper pages empty -> R6 FFh
        mem_access(1, 0, 23'h8123, 0, 0, 0, "R3");
        mem_access(1, 0, 23'hC000, 0, 0, 0, "R6");
        // R2 foreign port ignored
        io_write(8'hA9, 8'h55);
        io_read(8'hA8, "R2");
        io_read(8'hA9, "R2");
        mem_access(1, 0, 23'h4000, 0, 0, 0, "R2");
        // R4 carts
        io_write(8'hA8, 8'b10_01_10_01);
        io_read(8'hA8, "R2");
        mem_access(1, 0, 23'h0000, 0, 0, 0, "R4");
        mem_access(0, 1, 23'h7FFF, 0, 0, 0, "R4");
        mem_access(1, 0, 23'hBFFF, 0, 0, 0, "R4");
        // R7 FFFFh not intercepted when page 3 is not slot 3
        mem_access(0, 1, 23'hFFFF, 8'h3C, 0, 0, "R7");
        mem_access(1, 0, 23'hFFFF, 0, 0, 0, "R7");
        // R8 write visible in the same cycle as a memory read
        mem_access(1, 0, 23'hC004, 8'hFF, 1, 8'hA8, "R8");
        // R7 secondary write/read inverse
        mem_access(0, 1, 23'hFFFF, 8'b00_01_01_01, 0, 0, "R7");
        mem_access(1, 0, 23'hFFFF, 0, 0, 0, "R7");
        // R5 sub-slot 1 map
        mem_access(1, 0, 23'h0100, 0, 0, 0, "R5");
        mem_access(1, 0, 23'h4100, 0, 0, 0, "R5");
        mem_access(1, 0, 23'h8100, 0, 0, 0, "R5");
        mem_access(1, 0, 23'hC100, 0, 0, 0, "R5");
        mem_access(0, 1, 23'hFFFF, 8'b00_11_10_00, 0, 0, "R5");
        mem_access(1, 0, 23'h0200, 0, 0, 0, "R5");
        mem_access(1, 0, 23'h4200, 0, 0, 0, "R5");
        mem_access(1, 0, 23'h8200, 0, 0, 0, "R6");
        // R9 linear bypass
        mem_access(1, 0, 23'h010000, 0, 0, 0, "R9");
        mem_access(0, 1, 23'h7FFFFF, 0, 0, 0, "R9");

        // random mix, R10 exclusivity rides on every dev_cs check
        for (int i = 0; i < 400; i++) begin
            int k;
            logic [22:0] a;
            k = $urandom_range(0, 9);
            a = {7'd0, 16'($urandom)};
            if ($urandom_range(0, 7) == 0) a[22:16] = 7'($urandom_range(1, 127));
            if (k == 0)
                io_write(8'hA8, 8'($urandom));
            else if (k == 1)
                mem_access(0, 1, 23'hFFFF, 8'($urandom), 0, 0, "R7");
            else if (k == 2)
                io_read(8'hA8, "R2");
            else if (k == 3)
                mem_access(1, 0, a, 8'($urandom), 1, 8'hA8, "R8");
            else
                mem_access(k[0], !k[0], a, 8'($urandom), 0, 0, "R10");
        end

        @(negedge clk);
        idle_inputs();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule